// File: doc/BRIEF.md
# CEC Signal-Free-Time Timer

This block tells the transmit side of a CEC controller when the bus has stayed idle long enough for a new frame to start. Once it is armed, it counts half-bit ticks from the bit-rate prescaler while the line stays high. A low level on the line at any clock edge sends the count back to zero. When the count reaches the required wait, the block raises a registered `line_free` flag. The transmitter uses that flag to gate the start of its frame, and it pulses `tx_begin` when the frame actually starts. That pulse drops the flag and disarms the timer.

The required wait is chosen by a 3-bit setting:

- **Nonzero setting n:** the wait is n − 0.5 bit periods, which is 2n − 1 half-bit ticks.
- **Setting of zero:** the wait follows the protocol defaults:
  - 3 bit periods for a retry;
  - 7 bit periods after this node's own transmission;
  - 5 bit periods for a new initiator.

A mode bit selects what arms the timer. With the bit clear, the software transmit-start request arms it. With the bit set, the end of any transmitted or received frame arms it. The wait length is captured when the timer is armed.

Top module: `sft_line_timer`

## Requirements
- R1: Synchronous reset clears `line_free` and leaves the timer disarmed. Without an arm event, no number of half-bit ticks raises `line_free`.
- R2: For a nonzero setting n (1..7), `line_free` rises on the clock edge that samples the (2n−1)-th qualifying tick after arming. `own_last` and `retry` have no effect on this wait.
- R3: Setting 0 with `retry`=0 and `own_last`=0 gives a wait of 10 ticks (5 bit periods).
- R4: Setting 0 with `retry`=0 and `own_last`=1 gives a wait of 14 ticks (7 bit periods).
- R5: Setting 0 with `retry`=1 gives a wait of 6 ticks (3 bit periods), whatever the value of `own_last`.
- R6: With `start_opt`=0, a `tx_start_req` pulse arms the timer, and `tx_end` and `rx_end` pulses are ignored.
- R7: With `start_opt`=1, a `tx_end` or `rx_end` pulse arms the timer, and `tx_start_req` is ignored.
- R8: A low `line_level` at a clock edge while the timer is armed resets the count to zero. A low level never lets `line_free` rise at that edge.
- R9: Once `line_free` is high, it stays high until `tx_begin`. `tx_begin` clears it on the next edge and disarms the timer, so later ticks do not raise it again.
- R10: The wait is captured at the arm event. Later changes to the setting, `own_last` or `retry` do not change the wait that is in progress.
- R11: An arm event while the timer is already armed clears `line_free` and restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sft_cfg | input | 3 | Wait setting; 0 selects the protocol defaults |
| start_opt | input | 1 | 0: arm on transmit-start request; 1: arm at end of frame |
| tx_start_req | input | 1 | Software transmit-start request pulse |
| tx_end | input | 1 | End-of-transmission pulse |
| rx_end | input | 1 | End-of-reception pulse |
| half_tick | input | 1 | Half-bit-period tick from the prescaler |
| line_level | input | 1 | Sampled CEC line level (1 = released/high) |
| own_last | input | 1 | The last frame was this node's own transmission |
| retry | input | 1 | The next transmission is a retry |
| tx_begin | input | 1 | Pulse when the transmitter starts a frame |
| line_free | output | 1 | Bus idle long enough; transmit may start |

## Verification
The main sweep covers every setting value crossed with every `own_last`/`retry` combination, in both arming modes. In the end-of-frame mode it alternates between the transmit-end and receive-end pulses. For each combination it checks `line_free` after every single tick, which separates an off-by-one target from a correct one and shows that the flag-holding and disarm behaviour appear after the target is reached. Directed patterns then cover the remaining cases:

- arm pulses sent in the wrong mode;
- a line-low glitch partway through a count;
- a setting changed after arming;
- a re-arm while the flag is already high.

Each of these shows something the sweep cannot: ignored events, the count restart, the captured target and the restart on re-arm.

// File: rtl/sft_pkg.sv
package sft_pkg;

  // Largest wait, in half-bit ticks, over all settings and defaults.
  function automatic int half_target_max(input int cfg_w, input int d_new,
                                         input int d_own, input int d_retry);
    int m;
    m = 2 * ((1 << cfg_w) - 1) - 1;
    if (2 * d_new > m) m = 2 * d_new;
    if (2 * d_own > m) m = 2 * d_own;
    if (2 * d_retry > m) m = 2 * d_retry;
    return m;
  endfunction

  typedef enum logic [1:0] {
    WAIT_NEW   = 2'd0,
    WAIT_OWN   = 2'd1,
    WAIT_RETRY = 2'd2
  } default_wait_e;

endpackage

// File: rtl/sft_target.sv
// Selects the wait length in half-bit ticks from the setting and context flags.
module sft_target #(
  parameter int CFG_W     = 3,
  parameter int DEF_NEW   = 5,
  parameter int DEF_OWN   = 7,
  parameter int DEF_RETRY = 3,
  parameter int CNT_W     = 4
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             own_last,
  input  logic             retry,
  output logic [CNT_W-1:0] target
);
  import sft_pkg::*;

  localparam logic [CNT_W-1:0] T_NEW   = CNT_W'(2 * DEF_NEW);
  localparam logic [CNT_W-1:0] T_OWN   = CNT_W'(2 * DEF_OWN);
  localparam logic [CNT_W-1:0] T_RETRY = CNT_W'(2 * DEF_RETRY);

  default_wait_e    kind;
  logic [CNT_W-1:0] n_ext;

  always_comb begin
    if (retry)         kind = WAIT_RETRY;
    else if (own_last) kind = WAIT_OWN;
    else               kind = WAIT_NEW;
  end

  always_comb begin
    n_ext = CNT_W'(cfg);
    if (cfg != '0) begin
      target = (n_ext << 1) - CNT_W'(1);
    end else begin
      case (kind)
        WAIT_RETRY: target = T_RETRY;
        WAIT_OWN:   target = T_OWN;
        default:    target = T_NEW;
      endcase
    end
  end

endmodule

// File: rtl/sft_arm.sv
// Decodes which event arms the timer, according to the start option.
module sft_arm (
  input  logic start_opt,
  input  logic tx_start_req,
  input  logic tx_end,
  input  logic rx_end,
  output logic arm
);
  always_comb begin
    if (start_opt) arm = tx_end | rx_end;
    else           arm = tx_start_req;
  end
endmodule

// File: rtl/sft_counter.sv
// Half-bit counter with captured target and registered free flag.
module sft_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             tx_begin,
  input  logic             half_tick,
  input  logic             line_level,
  input  logic [CNT_W-1:0] target_in,
  output logic             line_free
);
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tgt;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      cnt       <= '0;
      tgt       <= '0;
      line_free <= 1'b0;
    end else if (tx_begin) begin
      armed     <= 1'b0;
      cnt       <= '0;
      line_free <= 1'b0;
    end else if (arm) begin
      armed     <= 1'b1;
      cnt       <= '0;
      tgt       <= target_in;
      line_free <= 1'b0;
    end else if (armed && !line_free) begin
      if (!line_level) begin
        cnt <= '0;
      end else if (half_tick) begin
        cnt <= cnt_nx;
        if (cnt_nx == tgt) line_free <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sft_line_timer.sv
module sft_line_timer #(
  parameter int CFG_W     = 3,
  parameter int DEF_NEW   = 5,
  parameter int DEF_OWN   = 7,
  parameter int DEF_RETRY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] sft_cfg,
  input  logic             start_opt,
  input  logic             tx_start_req,
  input  logic             tx_end,
  input  logic             rx_end,
  input  logic             half_tick,
  input  logic             line_level,
  input  logic             own_last,
  input  logic             retry,
  input  logic             tx_begin,
  output logic             line_free
);
  localparam int MAX_T = sft_pkg::half_target_max(CFG_W, DEF_NEW, DEF_OWN, DEF_RETRY);
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             arm;
  logic [CNT_W-1:0] target;

  sft_arm u_arm (
    .start_opt    (start_opt),
    .tx_start_req (tx_start_req),
    .tx_end       (tx_end),
    .rx_end       (rx_end),
    .arm          (arm)
  );

  sft_target #(
    .CFG_W(CFG_W), .DEF_NEW(DEF_NEW), .DEF_OWN(DEF_OWN),
    .DEF_RETRY(DEF_RETRY), .CNT_W(CNT_W)
  ) u_target (
    .cfg      (sft_cfg),
    .own_last (own_last),
    .retry    (retry),
    .target   (target)
  );

  sft_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .tx_begin   (tx_begin),
    .half_tick  (half_tick),
    .line_level (line_level),
    .target_in  (target),
    .line_free  (line_free)
  );
endmodule

// File: rtl/sft_line_timer_chk.sv
module sft_line_timer_chk (
  input logic clk,
  input logic rst,
  input logic start_opt,
  input logic tx_start_req,
  input logic tx_end,
  input logic rx_end,
  input logic half_tick,
  input logic line_level,
  input logic tx_begin,
  input logic line_free
);
  logic arm_ev;
  assign arm_ev = start_opt ? (tx_end | rx_end) : tx_start_req;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !line_free);

  assert_begin_clears_R9: assert property (@(posedge clk) disable iff (rst)
    tx_begin |=> !line_free);

  assert_flag_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (line_free && !tx_begin && !arm_ev) |=> line_free);

  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(line_free) |-> ($past(half_tick) && $past(line_level)));

  assert_low_blocks_rise_R8: assert property (@(posedge clk) disable iff (rst)
    !line_level |=> !$rose(line_free));

  assert_rearm_clears_R11: assert property (@(posedge clk) disable iff (rst)
    arm_ev |=> !line_free);
endmodule

bind sft_line_timer sft_line_timer_chk i_chk (
  .clk(clk), .rst(rst), .start_opt(start_opt), .tx_start_req(tx_start_req),
  .tx_end(tx_end), .rx_end(rx_end), .half_tick(half_tick),
  .line_level(line_level), .tx_begin(tx_begin), .line_free(line_free)
);

// File: tb/test_sft_line_timer.sv
module test_sft_line_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sft_cfg = '0;
  logic       start_opt = 1'b0, tx_start_req = 1'b0, tx_end = 1'b0, rx_end = 1'b0;
  logic       half_tick = 1'b0, line_level = 1'b1, own_last = 1'b0, retry = 1'b0;
  logic       tx_begin = 1'b0;
  logic       line_free;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  reported = 0;

  always #4 clk = ~clk;

  sft_line_timer i_sft_line_timer (
    .clk(clk), .rst(rst), .sft_cfg(sft_cfg), .start_opt(start_opt),
    .tx_start_req(tx_start_req), .tx_end(tx_end), .rx_end(rx_end),
    .half_tick(half_tick), .line_level(line_level), .own_last(own_last),
    .retry(retry), .tx_begin(tx_begin), .line_free(line_free)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: line_free=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs change at negedge; the flag is read at the following negedge.
  task automatic tick_once();
    half_tick = 1'b1;
    @(negedge clk);
    half_tick = 1'b0;
    @(negedge clk);
  endtask

  // kind: 0 start request, 1 transmit end, 2 receive end
  task automatic arm_evt(input int kind);
    tx_start_req = (kind == 0);
    tx_end       = (kind == 1);
    rx_end       = (kind == 2);
    @(negedge clk);
    tx_start_req = 1'b0; tx_end = 1'b0; rx_end = 1'b0;
  endtask

  task automatic begin_tx();
    tx_begin = 1'b1;
    @(negedge clk);
    tx_begin = 1'b0;
  endtask

  function automatic int exp_target(input int c, input bit o, input bit r);
    if (c != 0) return 2 * c - 1;
    if (r) return 6;
    if (o) return 14;
    return 10;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: line_free=%b expected=done", line_free);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(line_free, 1'b0, "R1 reset");
    for (int i = 0; i < 20; i++) tick_once();
    check(line_free, 1'b0, "R1 ticks without arm");

    // Sweep: every setting, context flag pair and arming mode.
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        for (int ctx = 0; ctx < 4; ctx++) begin
          int    t;
          string tag;
          start_opt = m[0]; sft_cfg = c[2:0];
          own_last = ctx[0]; retry = ctx[1];
          t = exp_target(c, own_last, retry);
          if (c != 0)     tag = "R2 nonzero setting";
          else if (retry) tag = "R5 retry default";
          else if (own_last) tag = "R4 own default";
          else            tag = "R3 new default";
          arm_evt(m == 0 ? 0 : 1 + (ctx % 2));
          check(line_free, 1'b0, m == 0 ? "R6 armed by request" : "R7 armed by frame end");
          for (int i = 1; i <= t; i++) begin
            tick_once();
            check(line_free, (i >= t), tag);
          end
          tick_once();
          check(line_free, 1'b1, "R9 flag holds");
          begin_tx();
          check(line_free, 1'b0, "R9 cleared by tx_begin");
          tick_once();
          check(line_free, 1'b0, "R9 disarmed");
        end
      end
    end

    // R6: frame-end pulses ignored in request mode.
    start_opt = 1'b0; sft_cfg = 3'd1; own_last = 0; retry = 0;
    arm_evt(1); arm_evt(2);
    for (int i = 0; i < 16; i++) tick_once();
    check(line_free, 1'b0, "R6 frame end ignored");

    // R7: request ignored in frame-end mode.
    start_opt = 1'b1;
    arm_evt(0);
    for (int i = 0; i < 16; i++) tick_once();
    check(line_free, 1'b0, "R7 request ignored");

    // R8: line low mid-count restarts the count (setting 3 -> 5 ticks).
    start_opt = 1'b0; sft_cfg = 3'd3;
    arm_evt(0);
    for (int i = 0; i < 4; i++) tick_once();
    line_level = 1'b0; half_tick = 1'b1;
    @(negedge clk);
    line_level = 1'b1; half_tick = 1'b0;
    check(line_free, 1'b0, "R8 low line");
    for (int i = 0; i < 4; i++) tick_once();
    check(line_free, 1'b0, "R8 count restarted");
    tick_once();
    check(line_free, 1'b1, "R8 full wait after low");
    begin_tx();

    // R10: setting changed after arming does not alter the wait.
    sft_cfg = 3'd2;
    arm_evt(0);
    sft_cfg = 3'd7; retry = 1'b1;
    for (int i = 0; i < 2; i++) tick_once();
    check(line_free, 1'b0, "R10 before captured wait");
    tick_once();
    check(line_free, 1'b1, "R10 captured wait");
    begin_tx();
    retry = 1'b0;

    // R11: re-arm while free clears and restarts.
    sft_cfg = 3'd1;
    arm_evt(0);
    tick_once();
    check(line_free, 1'b1, "R11 first wait");
    sft_cfg = 3'd2;
    arm_evt(0);
    check(line_free, 1'b0, "R11 cleared by re-arm");
    for (int i = 0; i < 2; i++) tick_once();
    check(line_free, 1'b0, "R11 restarted count");
    tick_once();
    check(line_free, 1'b1, "R11 new wait reached");
    begin_tx();

    report();
  end
endmodule